// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the control side of a four-channel DMA engine. A host writes single bytes to eight control offsets (8 through 15) of the controller's port window. These writes set the command word, raise or drop software transfer requests, mask or unmask channels one at a time or all together, store each channel's mode byte, pulse a clear to the byte-pointer flip-flop, and run a master reset. Writes to offsets 0 through 7 belong to the address and count registers, which live in another block, and are ignored here.

A status byte combines two things. The upper nibble holds the request bits, one per channel. The lower nibble holds the terminal-count flags. Both the register interface and the sideband inputs change these bits. The transfer engine sends per-channel hold and release pulses and terminal-count pulses. A status read strobe clears the terminal-count flags. When software and a sideband pulse act on the same bit in the same cycle, the sideband pulse takes effect.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After reset, mask_o is all ones, and status_o, cmd_o, every mode byte, ff_clr_o and cmd_err_o are zero.
- R2: A write whose offset has bit 3 clear (offsets 0 to 7) changes no output of this block.
- R3: A write to offset 9 selects channel c = data[1:0]. It sets status bit c+4 when data[2] is 1, clears it when data[2] is 0, and always clears status bit c. No other status bit changes.
- R4: A write to offset 10 selects channel c = data[1:0]. It sets mask bit c when data[2] is 1 and clears it otherwise. The other mask bits are kept.
- R5: A write to offset 11 stores the whole data byte as the mode of channel data[1:0]. The byte layout is [1:0] channel, [3:2] transfer type, [4] auto-init, [5] address decrement, [7:6] transfer mode. Channel c's mode appears on mode_o[8c+7:8c]. The other channels' modes are kept.
- R6: A write to offset 12 or 13 makes ff_clr_o high for exactly the one cycle after the write.
- R7: A write to offset 13 sets the mask to all ones and clears status, command and cmd_err_o. Mode bytes are kept.
- R8: A write to offset 14 clears every mask bit. A write to offset 15 loads the mask from data[3:0].
- R9: A write to offset 8 is accepted only if no bit other than bit 2 is set (zero is always accepted). Any other value leaves cmd_o unchanged and sets cmd_err_o, which stays set until a master reset.
- R10: A hold_req[c] pulse sets status bit c+4 and a rel_req[c] pulse clears it. Hold wins over release in the same cycle, and either pulse wins over a register write or master reset that touches the same bit in that cycle.
- R11: A tc_hit[c] pulse sets status bit c. A stat_rd strobe clears all terminal-count bits in the next cycle. A tc_hit arriving in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Port offset of the write |
| wr_data | input | 8 | Write data byte |
| stat_rd | input | 1 | Status read strobe; clears terminal-count flags |
| hold_req | input | 4 | Per-channel external request-set pulse |
| rel_req | input | 4 | Per-channel external request-clear pulse |
| tc_hit | input | 4 | Per-channel terminal-count pulse |
| mask_o | output | 4 | Channel mask, bit c masks channel c |
| status_o | output | 8 | Requests in [7:4], terminal counts in [3:0] |
| cmd_o | output | 8 | Accepted command word |
| mode_o | output | 32 | Four mode bytes, channel c at [8c+7:8c] |
| ff_clr_o | output | 1 | One-cycle byte-pointer flip-flop clear |
| cmd_err_o | output | 1 | Unsupported command was written |

## Verification
The bench targets collisions on a single status bit. These are hold against release, release against a software set, hold against master reset, and terminal-count set against a read clear. A design with the wrong priority would drop a hardware request or lose a terminal count. It also checks that an offset-9 write clears the chosen channel's terminal-count bit while leaving its neighbours alone, and that an illegal command leaves the old command in place and keeps the error flag set across later legal writes. Mode bytes must survive a master reset, and writes below offset 8 must have no effect. A decoder that ignored address bit 3 would corrupt the mask or command.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

   // Control offsets relative to 8 (wr_addr[2:0] when wr_addr[3] is set)
   typedef enum logic [2:0] {
      OFS_CMD   = 3'd0,
      OFS_REQ   = 3'd1,
      OFS_SMASK = 3'd2,
      OFS_MODE  = 3'd3,
      OFS_FFCLR = 3'd4,
      OFS_MRST  = 3'd5,
      OFS_MCLR  = 3'd6,
      OFS_MALL  = 3'd7
   } ctl_ofs_e;

   typedef struct packed {
      logic w_cmd;
      logic w_req;
      logic w_smask;
      logic w_mode;
      logic w_ffclr;
      logic w_mrst;
      logic w_mclr;
      logic w_mall;
   } ctl_strb_t;

   // Only the controller-disable bit of the command word is supported
   localparam logic [7:0] CMD_OK_BITS = 8'h04;

endpackage

// File: rtl/dmac_ctl_decode.sv
module dmac_ctl_decode
   import dmac_ctl_pkg::*;
(
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   output ctl_strb_t  strb
);

   logic in_win;
   assign in_win = wr_en & wr_addr[3];

   always_comb begin
      strb = '0;
      if (in_win) begin
         case (ctl_ofs_e'(wr_addr[2:0]))
            OFS_CMD:   strb.w_cmd   = 1'b1;
            OFS_REQ:   strb.w_req   = 1'b1;
            OFS_SMASK: strb.w_smask = 1'b1;
            OFS_MODE:  strb.w_mode  = 1'b1;
            OFS_FFCLR: strb.w_ffclr = 1'b1;
            OFS_MRST:  strb.w_mrst  = 1'b1;
            OFS_MCLR:  strb.w_mclr  = 1'b1;
            default:   strb.w_mall  = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/dmac_ctl_mask.sv
module dmac_ctl_mask
   import dmac_ctl_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W = $clog2(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_strb_t         strb,
   input  logic [CH_W-1:0]   ch_sel,
   input  logic              bit_val,
   input  logic [NUM_CH-1:0] all_val,
   output logic [NUM_CH-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (strb.w_mrst)
         mask_q <= '1;
      else if (strb.w_mclr)
         mask_q <= '0;
      else if (strb.w_mall)
         mask_q <= all_val;
      else if (strb.w_smask)
         mask_q[ch_sel] <= bit_val;
   end

   p_mrst_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strb.w_mrst |=> (mask_q == '1));

   p_mclr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      strb.w_mclr |=> (mask_q == '0));

   p_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      strb.w_smask |=> (mask_q[$past(ch_sel)] == $past(bit_val)));

endmodule

// File: rtl/dmac_ctl_status.sv
module dmac_ctl_status
   import dmac_ctl_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W = $clog2(NUM_CH)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  ctl_strb_t           strb,
   input  logic [CH_W-1:0]     ch_sel,
   input  logic                set_val,
   input  logic                rd_clr,
   input  logic [NUM_CH-1:0]   hold_req,
   input  logic [NUM_CH-1:0]   rel_req,
   input  logic [NUM_CH-1:0]   tc_hit,
   output logic [2*NUM_CH-1:0] status_q
);

   logic [NUM_CH-1:0] req_q;
   logic [NUM_CH-1:0] tc_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = strb.w_req && (ch_sel == CH_W'(i));

      // request bit: sideband pulses outrank register writes
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           req_q[i] <= 1'b0;
         else if (hold_req[i]) req_q[i] <= 1'b1;
         else if (rel_req[i])  req_q[i] <= 1'b0;
         else if (strb.w_mrst) req_q[i] <= 1'b0;
         else if (sel)         req_q[i] <= set_val;
      end

      // terminal-count bit: a new count outranks every clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          tc_q[i] <= 1'b0;
         else if (tc_hit[i])                  tc_q[i] <= 1'b1;
         else if (strb.w_mrst || rd_clr || sel) tc_q[i] <= 1'b0;
      end

      p_hold_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
         hold_req[i] |=> status_q[NUM_CH+i]);

      p_rel_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (rel_req[i] && !hold_req[i]) |=> !status_q[NUM_CH+i]);

      p_tc_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
         tc_hit[i] |=> status_q[i]);

      p_rd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_clr && !tc_hit[i]) |=> !status_q[i]);
   end

   assign status_q = {req_q, tc_q};

endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
   import dmac_ctl_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int DATA_W     = 8,
   parameter bit ERR_STICKY = 1'b1,
   localparam int CH_W = $clog2(NUM_CH)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [3:0]               wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     stat_rd,
   input  logic [NUM_CH-1:0]        hold_req,
   input  logic [NUM_CH-1:0]        rel_req,
   input  logic [NUM_CH-1:0]        tc_hit,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [2*NUM_CH-1:0]      status_o,
   output logic [DATA_W-1:0]        cmd_o,
   output logic [NUM_CH*DATA_W-1:0] mode_o,
   output logic                     ff_clr_o,
   output logic                     cmd_err_o
);

   localparam logic [DATA_W-1:0] CMD_OK = DATA_W'(CMD_OK_BITS);

   // elaboration-time parameter checks
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (DATA_W < 8 || 2*NUM_CH > DATA_W || CH_W > 2) begin : g_bad_w
      $error("DATA_W must hold the status byte and mode fields");
   end

   ctl_strb_t       strb;
   logic [CH_W-1:0] ch_sel;
   logic            cmd_bad;

   assign ch_sel  = wr_data[CH_W-1:0];
   assign cmd_bad = strb.w_cmd && ((wr_data & ~CMD_OK) != '0);

   dmac_ctl_decode u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .strb    (strb)
   );

   dmac_ctl_mask #(.NUM_CH(NUM_CH)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb    (strb),
      .ch_sel  (ch_sel),
      .bit_val (wr_data[2]),
      .all_val (wr_data[NUM_CH-1:0]),
      .mask_q  (mask_o)
   );

   dmac_ctl_status #(.NUM_CH(NUM_CH)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb     (strb),
      .ch_sel   (ch_sel),
      .set_val  (wr_data[2]),
      .rd_clr   (stat_rd),
      .hold_req (hold_req),
      .rel_req  (rel_req),
      .tc_hit   (tc_hit),
      .status_q (status_o)
   );

   // command word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmd_o <= '0;
      else if (strb.w_mrst)
         cmd_o <= '0;
      else if (strb.w_cmd && !cmd_bad)
         cmd_o <= wr_data;
   end

   // error flag variant
   if (ERR_STICKY) begin : g_err_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cmd_err_o <= 1'b0;
         else if (strb.w_mrst) cmd_err_o <= 1'b0;
         else if (cmd_bad)     cmd_err_o <= 1'b1;
      end
   end else begin : g_err_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmd_err_o <= 1'b0;
         else        cmd_err_o <= cmd_bad;
      end
   end

   // flip-flop clear pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_clr_o <= 1'b0;
      else        ff_clr_o <= strb.w_ffclr | strb.w_mrst;
   end

   // per-channel mode bytes
   for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
      logic [DATA_W-1:0] mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_q <= '0;
         else if (strb.w_mode && ch_sel == CH_W'(i))
            mode_q <= wr_data;
      end
      assign mode_o[i*DATA_W +: DATA_W] = mode_q;

      p_mode_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (strb.w_mode && ch_sel == CH_W'(i)) |=>
            (mode_o[i*DATA_W +: DATA_W] == $past(wr_data)));
   end

   p_ffclr_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[3] && wr_addr[2:1] == 2'b10) |=> ff_clr_o);

   p_ffclr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr[3] && wr_addr[2:1] == 2'b10) |=> !ff_clr_o);

   p_bad_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_bad |=> ($stable(cmd_o) && cmd_err_o));

   p_low_ofs_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[3] && hold_req == '0 && rel_req == '0 &&
       tc_hit == '0 && !stat_rd) |=>
         ($stable(mask_o) && $stable(cmd_o) && $stable(mode_o) &&
          $stable(status_o)));

endmodule

// File: tb/dmac_ctl_regs_tb.sv
module dmac_ctl_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        stat_rd = 1'b0;
   logic [3:0]  hold_req = '0;
   logic [3:0]  rel_req = '0;
   logic [3:0]  tc_hit = '0;
   logic [3:0]  mask_o;
   logic [7:0]  status_o;
   logic [7:0]  cmd_o;
   logic [31:0] mode_o;
   logic        ff_clr_o;
   logic        cmd_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   dmac_ctl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .stat_rd(stat_rd), .hold_req(hold_req),
      .rel_req(rel_req), .tc_hit(tc_hit), .mask_o(mask_o),
      .status_o(status_o), .cmd_o(cmd_o), .mode_o(mode_o),
      .ff_clr_o(ff_clr_o), .cmd_err_o(cmd_err_o)
   );

   // {req_no, addr, data, exp_mask, exp_status, exp_cmd}
   localparam int NVEC = 12;
   localparam logic [35:0] VEC [NVEC] = '{
      {4'd8, 4'hE, 8'h00, 4'h0, 8'h00, 8'h00},  // R8 clear all mask
      {4'd4, 4'hA, 8'h06, 4'h4, 8'h00, 8'h00},  // R4 mask ch2
      {4'd4, 4'hA, 8'h02, 4'h0, 8'h00, 8'h00},  // R4 unmask ch2
      {4'd8, 4'hF, 8'h09, 4'h9, 8'h00, 8'h00},  // R8 load mask
      {4'd3, 4'h9, 8'h05, 4'h9, 8'h20, 8'h00},  // R3 request ch1
      {4'd3, 4'h9, 8'h07, 4'h9, 8'hA0, 8'h00},  // R3 request ch3
      {4'd3, 4'h9, 8'h01, 4'h9, 8'h80, 8'h00},  // R3 drop ch1
      {4'd9, 4'h8, 8'h04, 4'h9, 8'h80, 8'h04},  // R9 legal command
      {4'd9, 4'h8, 8'h10, 4'h9, 8'h80, 8'h04},  // R9 illegal rejected
      {4'd2, 4'h3, 8'hFF, 4'h9, 8'h80, 8'h04},  // R2 low offset ignored
      {4'd9, 4'h8, 8'h00, 4'h9, 8'h80, 8'h00},  // R9 zero accepted
      {4'd7, 4'hD, 8'h00, 4'hF, 8'h00, 8'h00}   // R7 master reset
   };

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drv(input logic we, input logic [3:0] a, input logic [7:0] d,
                      input logic [3:0] h, input logic [3:0] r,
                      input logic [3:0] t, input logic rd);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      hold_req = h; rel_req = r; tc_hit = t; stat_rd = rd;
      @(negedge clk);
      wr_en = 1'b0; hold_req = '0; rel_req = '0; tc_hit = '0; stat_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      drv(1'b1, a, d, 4'h0, 4'h0, 4'h0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 mask", 32'(mask_o), 32'hF);
      chk("R1 status", 32'(status_o), 32'h0);
      chk("R1 cmd", 32'(cmd_o), 32'h0);
      chk("R1 mode", mode_o, 32'h0);
      chk("R1 ff_clr/err", {30'd0, ff_clr_o, cmd_err_o}, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][31:28], VEC[i][27:20]);
         chk($sformatf("R%0d vector %0d", VEC[i][35:32], i),
             {12'd0, mask_o, status_o, cmd_o}, {12'd0, VEC[i][19:0]});
      end
      chk("R7 err cleared", 32'(cmd_err_o), 32'h0);

      // R5 mode bytes
      wr(4'hB, 8'h96);
      chk("R5 mode ch2", mode_o, 32'h0096_0000);
      wr(4'hB, 8'h5B);
      chk("R5 mode ch3", mode_o, 32'h5B96_0000);
      wr(4'hB, 8'h28);
      chk("R5 mode ch0", mode_o, 32'h5B96_0028);

      // R7 master reset keeps modes, R6 pulses flip-flop clear
      wr(4'hD, 8'h00);
      chk("R7 modes kept", mode_o, 32'h5B96_0028);
      chk("R6 ff_clr after reset write", 32'(ff_clr_o), 32'h1);

      // R6 one-cycle pulse
      wr(4'hC, 8'h00);
      chk("R6 ff_clr high", 32'(ff_clr_o), 32'h1);
      @(negedge clk);
      chk("R6 ff_clr low", 32'(ff_clr_o), 32'h0);

      // R9 sticky error
      wr(4'h8, 8'h01);
      chk("R9 cmd unchanged", 32'(cmd_o), 32'h0);
      chk("R9 err set", 32'(cmd_err_o), 32'h1);
      wr(4'h8, 8'h04);
      chk("R9 legal after error", 32'(cmd_o), 32'h4);
      chk("R9 err sticky", 32'(cmd_err_o), 32'h1);
      wr(4'hD, 8'h00);
      chk("R7 err cleared", {cmd_o, 23'd0, cmd_err_o}, 32'h0);

      // R10 sideband request pulses
      drv(1'b0, 4'h0, 8'h00, 4'h1, 4'h0, 4'h0, 1'b0);
      chk("R10 hold ch0", 32'(status_o), 32'h10);
      drv(1'b0, 4'h0, 8'h00, 4'h2, 4'h2, 4'h0, 1'b0);
      chk("R10 hold beats release", 32'(status_o), 32'h30);
      drv(1'b1, 4'h9, 8'h04, 4'h0, 4'h1, 4'h0, 1'b0);
      chk("R10 release beats write", 32'(status_o), 32'h20);
      drv(1'b1, 4'hD, 8'h00, 4'h4, 4'h0, 4'h0, 1'b0);
      chk("R10 hold beats master reset", 32'(status_o), 32'h40);
      drv(1'b0, 4'h0, 8'h00, 4'h0, 4'h4, 4'h0, 1'b0);
      chk("R10 release ch2", 32'(status_o), 32'h00);

      // R11 terminal count
      drv(1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h8, 1'b0);
      chk("R11 tc ch3", 32'(status_o), 32'h08);
      drv(1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);
      chk("R11 read clears", 32'(status_o), 32'h00);
      drv(1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h2, 1'b1);
      chk("R11 tc beats read", 32'(status_o), 32'h02);
      drv(1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h1, 1'b0);
      chk("R11 tc ch0", 32'(status_o), 32'h03);
      wr(4'h9, 8'h01);
      chk("R3 write clears tc ch1", 32'(status_o), 32'h01);
      wr(4'h9, 8'h04);
      chk("R3 write clears tc ch0, sets req", 32'(status_o), 32'h10);

      // R2 low offset with data that would hit every register
      wr(4'h5, 8'hFF);
      chk("R2 no change", {12'd0, mask_o, status_o, cmd_o}, 32'h000F_1000);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule